// File: doc/BRIEF.md
# Deficit Weighted Round Robin Egress Scheduler

This block chooses which of four egress queues of one switch port sends its next frame. Queue 0 has strict priority. Queues 1 to 3 share the remaining bandwidth in proportion to a programmable byte weight for each queue. The scheduler sees each queue as a non-empty flag and the byte length of the frame at its head. It answers with a one-hot grant and the captured frame length. It then holds that grant until the transmit side pulses frame-done, and only after that does it decide again.

Each weighted queue has a signed credit counter. When the queue's turn begins, its weight is added to the counter. Each frame it sends subtracts the frame's length. The queue keeps the turn while its credit is at least one byte, so the last frame of a turn may overdraw the counter. In deficit mode the resulting debt is carried into the queue's next turn, which keeps long-run byte shares close to the programmed weights. A legacy mode starts every turn from the full weight instead, so the share of each queue can be compared with the carried-debt behaviour.

Top module: `dwrr_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grant` is all zeros, whatever the queue flags are.
- R2: `grant` has at most one bit set. A grant stays unchanged until `frameDone` is sampled high, and it is all zeros in the following cycle. `grantLen` equals the head length of the granted queue at the moment of the grant.
- R3: Bit 0 of `grant` and of `qNonEmpty` is the strict-priority queue. When the scheduler is idle and that queue is non-empty, it is granted in the next cycle, ahead of every weighted queue.
- R4: Bits 1, 2 and 3 are the weighted queues, which take turns in the cyclic order 1, 2, 3, 1, and so on. A weighted queue that is empty when its turn comes is skipped and receives no credit.
- R5: At the start of a turn the queue's weight is added to its credit. Each grant subtracts the head frame length. The queue keeps receiving grants while its credit is at least 1, even when the next frame is longer than the remaining credit. Its credit always stays above minus 2^LEN_W and below 2^WGT_W.
- R6: With `legacyMode` = 0 (deficit mode), a negative balance left at the end of a turn is kept. With a weight of 1600 and frames of 1500 bytes, the second turn starts at 200 and sends one frame.
- R7: With `legacyMode` = 1, every turn starts from exactly the weight, whatever the previous balance. With a weight of 1600 and frames of 1500 bytes, every turn sends two frames.
- R8: A queue that empties during its turn while its credit is still positive has its credit cleared to zero. A non-positive balance is left untouched.
- R9: In deficit mode with all weighted queues backlogged, and counting over whole rounds, the bytes of any two weighted queues i and j satisfy |Bi·Wj − Bj·Wi| ≤ 1518·(Wi + Wj).
- R10: Granting the strict-priority queue does not change the weighted queue's turn or its credit. Weighted service resumes with the same queue that held the turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qNonEmpty | input | NUM_WQ+1 | Per-queue non-empty flag; bit 0 is the strict-priority queue |
| headLenFlat | input | (NUM_WQ+1)*LEN_W | Head-of-queue frame length in bytes; queue q occupies bits [q*LEN_W +: LEN_W] |
| weightFlat | input | NUM_WQ*WGT_W | Byte weight of each weighted queue; weighted queue k (bit k+1) occupies bits [k*WGT_W +: WGT_W] |
| legacyMode | input | 1 | 1 = each turn starts from the full weight; 0 = carry the deficit |
| frameDone | input | 1 | Pulse that ends the frame currently granted |
| grant | output | NUM_WQ+1 | One-hot selection of the queue that sends next |
| grantLen | output | LEN_W | Head length captured when the grant was issued |

## Verification
The bench builds the block with its default parameters: three weighted queues, 11-bit lengths, 16-bit weights and 18-bit credits. This is small enough that a frame-level reference model, written from the requirements, can predict the queue and the length of every single grant across several weight sets and both modes. Fixed 1500-byte frames with 1600-byte weights reproduce the exact grant orders that distinguish carried debt from a full refill. Pseudo-random lengths from 64 to 1518 bytes drive the fairness check, which measures bytes over whole rounds. Timed scenarios pin the cycle in which the priority grant appears, the clearing of positive credit when a queue empties, and the resumption of the interrupted turn.

// File: rtl/dwrr_pkg.sv
package dwrr_pkg;
  // Width of the queue selector carried in the strobe bundle.
  parameter int unsigned SEL_W = 4;

  // Control-to-datapath strobes, one action per cycle on queue 'sel'.
  typedef struct packed {
    logic             turnStart;
    logic             charge;
    logic             clearPos;
    logic [SEL_W-1:0] sel;
  } credStrobe_t;
endpackage

// File: rtl/dwrr_credit_dp.sv
module dwrr_credit_dp
  import dwrr_pkg::*;
#(
  parameter int unsigned NUM_WQ = 3,
  parameter int unsigned WGT_W  = 16,
  parameter int unsigned LEN_W  = 11,
  parameter int unsigned CRED_W = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  credStrobe_t              strb,
  input  logic [NUM_WQ*WGT_W-1:0]  weightFlat,
  input  logic                     legacyMode,
  input  logic [LEN_W-1:0]         chargeLen,
  output logic [NUM_WQ*CRED_W-1:0] creditFlat,
  output logic                     selPositive
);
  logic signed [CRED_W-1:0] lenExt;
  assign lenExt = signed'({{(CRED_W-LEN_W){1'b0}}, chargeLen});

  for (genvar gi = 0; gi < NUM_WQ; gi++) begin : g_cred
    logic signed [CRED_W-1:0] credQ;
    logic signed [CRED_W-1:0] wExt;
    logic                     hit;
    assign wExt = signed'({{(CRED_W-WGT_W){1'b0}}, weightFlat[gi*WGT_W +: WGT_W]});
    assign hit  = (strb.sel == SEL_W'(gi));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        credQ <= '0;
      end else if (hit) begin
        if (strb.turnStart)     credQ <= legacyMode ? wExt : credQ + wExt;
        else if (strb.charge)   credQ <= credQ - lenExt;
        else if (strb.clearPos) credQ <= '0;
      end
    end

    assign creditFlat[gi*CRED_W +: CRED_W] = credQ;
  end

  always_comb begin
    logic signed [CRED_W-1:0] c;
    selPositive = 1'b0;
    for (int i = 0; i < NUM_WQ; i++) begin
      c = signed'(creditFlat[i*CRED_W +: CRED_W]);
      if (strb.sel == SEL_W'(i)) selPositive = (c > 0);
    end
  end
endmodule

// File: rtl/dwrr_ctrl.sv
module dwrr_ctrl
  import dwrr_pkg::*;
#(
  parameter int unsigned NUM_WQ = 3,
  localparam int unsigned NUM_Q = NUM_WQ + 1,
  localparam int unsigned IDX_W = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_Q-1:0] qNonEmpty,
  input  logic             selPositive,
  input  logic             frameDone,
  output credStrobe_t      strb,
  output logic             fire,
  output logic [IDX_W-1:0] fireIdx,
  output logic [NUM_Q-1:0] grant
);
  logic             busyQ;
  logic             activeQ;
  logic             activeNext;
  logic             advance;
  logic [IDX_W-1:0] ptrQ;
  logic [IDX_W-1:0] wIdx;
  logic             curNonEmpty;

  assign wIdx        = ptrQ + 1'b1;
  assign curNonEmpty = qNonEmpty[wIdx];

  always_comb begin
    strb       = '0;
    strb.sel   = SEL_W'(ptrQ);
    fire       = 1'b0;
    fireIdx    = '0;
    advance    = 1'b0;
    activeNext = activeQ;
    if (!busyQ) begin
      if (qNonEmpty[0]) begin
        fire = 1'b1;
      end else if (!activeQ) begin
        if (curNonEmpty) begin
          strb.turnStart = 1'b1;
          activeNext     = 1'b1;
        end else begin
          advance = 1'b1;
        end
      end else if (curNonEmpty && selPositive) begin
        strb.charge = 1'b1;
        fire        = 1'b1;
        fireIdx     = wIdx;
      end else begin
        strb.clearPos = !curNonEmpty && selPositive;
        activeNext    = 1'b0;
        advance       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      activeQ <= 1'b0;
      ptrQ    <= '0;
      grant   <= '0;
    end else begin
      activeQ <= activeNext;
      if (advance) ptrQ <= (ptrQ == IDX_W'(NUM_WQ-1)) ? '0 : ptrQ + 1'b1;
      if (fire) begin
        busyQ <= 1'b1;
        grant <= NUM_Q'(1) << fireIdx;
      end else if (busyQ && frameDone) begin
        busyQ <= 1'b0;
        grant <= '0;
      end
    end
  end
endmodule

// File: rtl/dwrr_sched.sv
module dwrr_sched
  import dwrr_pkg::*;
#(
  parameter int unsigned NUM_WQ = 3,
  parameter int unsigned LEN_W  = 11,
  parameter int unsigned WGT_W  = 16,
  parameter int unsigned CRED_W = 18,
  localparam int unsigned NUM_Q = NUM_WQ + 1,
  localparam int unsigned IDX_W = $clog2(NUM_Q)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_Q-1:0]        qNonEmpty,
  input  logic [NUM_Q*LEN_W-1:0]  headLenFlat,
  input  logic [NUM_WQ*WGT_W-1:0] weightFlat,
  input  logic                    legacyMode,
  input  logic                    frameDone,
  output logic [NUM_Q-1:0]        grant,
  output logic [LEN_W-1:0]        grantLen
);
  credStrobe_t               strb;
  logic                      fire;
  logic [IDX_W-1:0]          fireIdx;
  logic                      selPositive;
  logic [LEN_W-1:0]          chargeLen;
  logic [NUM_WQ*CRED_W-1:0]  creditFlat;

  assign chargeLen = headLenFlat[fireIdx*LEN_W +: LEN_W];

  dwrr_ctrl #(.NUM_WQ(NUM_WQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .qNonEmpty(qNonEmpty), .selPositive(selPositive),
    .frameDone(frameDone), .strb(strb), .fire(fire), .fireIdx(fireIdx), .grant(grant)
  );

  dwrr_credit_dp #(.NUM_WQ(NUM_WQ), .WGT_W(WGT_W), .LEN_W(LEN_W), .CRED_W(CRED_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .weightFlat(weightFlat), .legacyMode(legacyMode),
    .chargeLen(chargeLen), .creditFlat(creditFlat), .selPositive(selPositive)
  );

  always_ff @(posedge clk) begin
    if (!rstN)     grantLen <= '0;
    else if (fire) grantLen <= chargeLen;
  end
endmodule

// File: rtl/dwrr_sched_chk.sv
module dwrr_sched_chk #(
  parameter int unsigned NUM_WQ = 3,
  parameter int unsigned LEN_W  = 11,
  parameter int unsigned WGT_W  = 16,
  parameter int unsigned CRED_W = 18,
  localparam int unsigned NUM_Q = NUM_WQ + 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_Q-1:0]         grant,
  input logic [NUM_Q-1:0]         qNonEmpty,
  input logic                     frameDone,
  input logic [NUM_WQ*CRED_W-1:0] creditFlat
);
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  p_grant_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0 && !frameDone) |=> grant == $past(grant));

  p_grant_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0 && frameDone) |=> grant == '0);

  p_sp_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (grant == '0 && qNonEmpty[0]) |=> grant[0]);

  for (genvar gi = 0; gi < NUM_WQ; gi++) begin : g_rng
    p_credit_range_r5: assert property (@(posedge clk) disable iff (!rstN)
      (signed'(creditFlat[gi*CRED_W +: CRED_W]) > -(2**LEN_W)) &&
      (signed'(creditFlat[gi*CRED_W +: CRED_W]) < (2**WGT_W)));
  end
endmodule

bind dwrr_sched dwrr_sched_chk #(
  .NUM_WQ(NUM_WQ), .LEN_W(LEN_W), .WGT_W(WGT_W), .CRED_W(CRED_W)
) u_chk (
  .clk(clk), .rstN(rstN), .grant(grant), .qNonEmpty(qNonEmpty),
  .frameDone(frameDone), .creditFlat(creditFlat)
);

// File: tb/dwrr_sched_tb.sv
`timescale 1ns/1ps
module dwrr_sched_tb;
  localparam int LEN_W = 11;
  localparam int WGT_W = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  qNonEmpty;
  logic [43:0] headLenFlat;
  logic [47:0] weightFlat;
  logic        legacyMode;
  logic        frameDone;
  logic [3:0]  grant;
  logic [10:0] grantLen;

  always #2.5 clk = ~clk;

  dwrr_sched u_dut (
    .clk(clk), .rstN(rstN), .qNonEmpty(qNonEmpty), .headLenFlat(headLenFlat),
    .weightFlat(weightFlat), .legacyMode(legacyMode), .frameDone(frameDone),
    .grant(grant), .grantLen(grantLen)
  );

  int errors = 0;
  int checks = 0;
  int qCount[4];
  int qIdx[4];
  int fixLen[4];
  int w[4];
  int seed;
  // reference model state
  int mCred[4];
  int mPtr;
  bit mActive;
  bit roundMark;
  longint bytes[4];
  longint firstB[4];
  longint snapB[4];
  bit haveFirst;
  int rounds;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lenOf(int q, int idx);
    if (fixLen[q] != 0) return fixLen[q];
    return 64 + ((idx * 397 + q * 211 + seed * 53) % 1455);
  endfunction

  task automatic refresh();
    for (int q = 0; q < 4; q++) begin
      qNonEmpty[q] = (qCount[q] > 0);
      headLenFlat[q*LEN_W +: LEN_W] = LEN_W'(lenOf(q, qIdx[q]));
    end
    for (int k = 0; k < 3; k++) weightFlat[k*WGT_W +: WGT_W] = WGT_W'(w[k+1]);
  endtask

  function automatic int predict();
    if (qCount[0] > 0) return 0;
    for (int g = 0; g < 24; g++) begin
      if (!mActive) begin
        if (qCount[mPtr] > 0) begin
          mCred[mPtr] = legacyMode ? w[mPtr] : mCred[mPtr] + w[mPtr];
          mActive = 1'b1;
          if (mPtr == 1) roundMark = 1'b1;
        end else mPtr = (mPtr == 3) ? 1 : mPtr + 1;
      end else if (qCount[mPtr] > 0 && mCred[mPtr] > 0) begin
        mCred[mPtr] -= lenOf(mPtr, qIdx[mPtr]);
        return mPtr;
      end else begin
        if (qCount[mPtr] == 0 && mCred[mPtr] > 0) mCred[mPtr] = 0;
        mActive = 1'b0;
        mPtr = (mPtr == 3) ? 1 : mPtr + 1;
      end
    end
    return -1;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    frameDone = 1'b0;
    for (int q = 0; q < 4; q++) begin
      mCred[q] = 0; bytes[q] = 0; qIdx[q] = 0;
    end
    mPtr = 1; mActive = 1'b0; roundMark = 1'b0; haveFirst = 1'b0; rounds = 0;
    refresh();
    repeat (3) @(negedge clk);
    chk(grant == 4'b0, "R1 grant during reset", int'(grant), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(grant == 4'b0, "R1 grant after reset", int'(grant), 0);
  endtask

  // Serves one frame; returns the granted queue.
  task automatic serveOne(input string tag, output int gq);
    int exp;
    int waitc;
    logic [3:0] held;
    exp = predict();
    if (roundMark) begin
      if (!haveFirst) begin
        for (int q = 0; q < 4; q++) firstB[q] = bytes[q];
        haveFirst = 1'b1;
      end else begin
        for (int q = 0; q < 4; q++) snapB[q] = bytes[q];
        rounds++;
      end
      roundMark = 1'b0;
    end
    waitc = 0;
    while (grant == 4'b0 && waitc < 64) begin
      @(negedge clk);
      waitc++;
    end
    gq = -1;
    for (int q = 0; q < 4; q++) if (grant[q]) gq = q;
    chk(exp >= 0 && grant == 4'(1 << exp), tag, gq, exp);
    if (exp >= 0) begin
      chk(int'(grantLen) == lenOf(exp, qIdx[exp]), "R2 grantLen", int'(grantLen), lenOf(exp, qIdx[exp]));
      bytes[exp] += lenOf(exp, qIdx[exp]);
    end
    held = grant;
    @(negedge clk);
    chk(grant == held, "R2 grant held", int'(grant), int'(held));
    frameDone = 1'b1;
    if (exp >= 0) begin
      qCount[exp]--;
      qIdx[exp]++;
    end
    refresh();
    @(negedge clk);
    frameDone = 1'b0;
    chk(grant == 4'b0, "R2 release after frameDone", int'(grant), 0);
  endtask

  task automatic setup(input bit leg, input int w1, input int w2, input int w3,
                       input int c1, input int c2, input int c3, input int l1, input int l2, input int l3);
    legacyMode = leg;
    w[0] = 0; w[1] = w1; w[2] = w2; w[3] = w3;
    qCount[0] = 0; qCount[1] = c1; qCount[2] = c2; qCount[3] = c3;
    fixLen[0] = 100; fixLen[1] = l1; fixLen[2] = l2; fixLen[3] = l3;
    doReset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gq;
    int expDef[8] = '{1, 1, 2, 2, 1, 2, 1, 2};
    int expLeg[8] = '{1, 1, 2, 2, 1, 1, 2, 2};
    int ws[4][3] = '{'{1600, 1600, 1600}, '{1000, 2000, 3000}, '{3000, 1500, 700}, '{5000, 1200, 2500}};
    seed = 0;
    qNonEmpty = '0; headLenFlat = '0; weightFlat = '0; legacyMode = 1'b0; frameDone = 1'b0;

    // R5/R6: weight 1600, frames 1500, deficit mode
    setup(1'b0, 1600, 1600, 0, 50, 50, 0, 1500, 1500, 0);
    for (int i = 0; i < 8; i++) begin
      serveOne("R5 deficit model", gq);
      chk(gq == expDef[i], "R6 deficit order", gq, expDef[i]);
    end

    // R7: same traffic, legacy mode
    setup(1'b1, 1600, 1600, 0, 50, 50, 0, 1500, 1500, 0);
    for (int i = 0; i < 8; i++) begin
      serveOne("R7 legacy model", gq);
      chk(gq == expLeg[i], "R7 legacy order", gq, expLeg[i]);
    end

    // R4: skip of empty queue 2, order 1,3,1,3
    setup(1'b0, 500, 500, 500, 10, 0, 10, 400, 400, 400);
    for (int i = 0; i < 6; i++) serveOne("R4 cyclic order with skip", gq);

    // R8: queue 1 empties with positive credit, then refilled
    setup(1'b0, 4000, 1000, 0, 1, 10, 0, 500, 600, 0);
    for (int i = 0; i < 4; i++) serveOne("R8 drain phase", gq);
    qCount[1] = 20; fixLen[1] = 1500; w[1] = 1000;
    refresh();
    for (int i = 0; i < 8; i++) serveOne("R8 credit cleared on empty", gq);

    // R3/R10: priority queue arrives during queue 1's turn
    setup(1'b0, 1600, 1600, 0, 20, 20, 0, 500, 500, 0);
    serveOne("R4 first weighted grant", gq);
    qCount[0] = 2;
    refresh();
    @(negedge clk);
    chk(grant == 4'b0001, "R3 priority grant next cycle", int'(grant), 1);
    serveOne("R3 priority first", gq);
    serveOne("R3 priority second", gq);
    serveOne("R10 weighted turn resumes", gq);
    chk(gq == 1, "R10 same queue resumes", gq, 1);
    for (int i = 0; i < 6; i++) serveOne("R10 weighted after priority", gq);

    // R9: fairness sweep, pseudo-random lengths
    for (int s = 0; s < 4; s++) begin
      seed = s + 1;
      setup(1'b0, ws[s][0], ws[s][1], ws[s][2], 100000, 100000, 100000, 0, 0, 0);
      for (int i = 0; i < 240; i++) serveOne("R9 fairness model", gq);
      chk(rounds >= 2, "R9 rounds completed", rounds, 2);
      for (int a = 1; a < 4; a++) begin
        for (int b = a + 1; b < 4; b++) begin
          longint ba = snapB[a] - firstB[a];
          longint bb = snapB[b] - firstB[b];
          longint diff = ba * w[b] - bb * w[a];
          longint lim = 1518 * longint'(w[a] + w[b]);
          if (diff < 0) diff = -diff;
          chk(diff <= lim, "R9 byte share ratio", int'(diff), int'(lim));
        end
      end
    end

    // R7: legacy with random lengths, model match only
    seed = 9;
    setup(1'b1, 2000, 900, 1300, 100000, 100000, 100000, 0, 0, 0);
    for (int i = 0; i < 120; i++) serveOne("R7 legacy random model", gq);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule